// File: doc/BRIEF.md
# Banked Legacy Interrupt Controller

This block gathers 64 interrupt sources into one request line for a processor. The sources form two banks of 32. Each bank has four word registers on a simple 32-bit bus: a latched event register, an enable mask, a write-one-to-clear acknowledge register and a read-only view of the live input lines. The block synchronises every input, records rising edges of enabled sources, and holds its request output high while any enabled source has a latched event or a high input line. Software reads both banks, combines event, level and enable itself, and services the highest-numbered pending source.

The banks are placed in reverse order inside a 64-byte window: the low bank is the one at the higher offset. Turning on an enable bit while its input is already high does not create a latched event. The source then requests only for as long as its line stays high. If software needs the interrupt to be remembered, it has to retrigger it itself.

The request output comes from a two-state machine. In state IRQ_QUIET the output is low. The transition QUIET_TO_RAISED happens on the first clock edge at which any source is pending. In state IRQ_RAISED the output is high. The transition RAISED_TO_QUIET happens on the first clock edge at which no source is pending.

Top module: `banked_intc`

## Requirements
- R1: After reset every enable bit and every event bit is 0, `irq_out` is 0, and `bus_rdata` is 0.
- R2: Sources 0 to 31 form bank 0, which sits at byte offset 0x20. Sources 32 to 63 form bank 1, which sits at offset 0x10. Source n maps to bank n>>5 at bit n&31. Inside a bank, the word offsets are +0x0 event, +0x4 enable, +0x8 acknowledge and +0xC level.
- R3: Reading an enable register returns the last value written to it. The enable register changes only when software writes it.
- R4: When an enabled source's synchronised input rises, its event bit is set. The event bit stays set after the input falls again.
- R5: A rising edge on a source whose enable bit is 0 does not set its event bit, and it does not raise `irq_out`.
- R6: Setting an enable bit while its input is already high leaves the event bit at 0. `irq_out` then follows the level of that line and falls when the line falls, because nothing was latched.
- R7: Writing 1 to a bit of an acknowledge register clears that event bit. Bits written as 0 leave their event bits unchanged. Reading the acknowledge register returns the bank's current event bits.
- R8: When a new rising edge on an enabled source meets an acknowledge of the same bit in the same cycle, the event bit ends up set.
- R9: The level register shows the input lines after a two-flop synchroniser. A change on an input reaches a read issued two clock edges later. Writes to the level register and to the event register are ignored.
- R10: Reads of undecoded offsets return 0, and writes to them change nothing. The undecoded offsets are byte offsets 0x00 to 0x0F, byte offsets 0x30 to 0x3F, and any offset whose two low bits are not 00.
- R11: `irq_out` is registered. It is 1 one cycle after any source in either bank satisfies (event OR level) AND enable. It is 0 one cycle after no source satisfies that condition.
- R12: A read completes in one cycle. `bus_rdata` takes the addressed value on the clock edge at which `bus_rd` is sampled high. It then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Interrupt source lines, asynchronous to `clk` |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 6 | Byte offset in the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench enables a source while its line is already high. A design that detected the enable change as an edge would report a latched event that never existed. The bench also lands a fresh rising edge in the same cycle as an acknowledge of that bit. A design that let the clear win would silently lose that interrupt. Further checks write zeros to an acknowledge register, write to the level and event registers, and access undecoded offsets. A decoder that was too loose would clear events it should keep, corrupt state, or return stale data. Finally, the bench measures the synchroniser delay on the level register and drives sources in both banks. This exposes a missing flop stage and a bank map with the order reversed.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register selected by address bits [3:2] inside one bank.
    typedef enum logic [1:0] {
        SEL_EVENT  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_LEVEL  = 2'd3
    } reg_sel_e;

    // States of the request output machine.
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int unsigned PAGE_LSB = 4;   // each bank occupies 16 bytes

endpackage

// File: rtl/intc_sync.sv
// Two-flop synchroniser plus rising-edge detector for one bank of lines.
module intc_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
    end

endmodule

// File: rtl/intc_bank.sv
// Event and enable storage for one bank of sources.
module intc_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise,
    input  logic             en_we,
    input  logic             ack_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] event_q,
    output logic [WIDTH-1:0] enable_q,
    output logic [WIDTH-1:0] pending
);

    logic [WIDTH-1:0] clear_mask;
    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] event_nx;

    always_comb begin
        clear_mask = ack_we ? wdata : '0;
        set_mask   = rise & enable_q;
        // A fresh edge overrides a clear of the same bit.
        event_nx   = (event_q & ~clear_mask) | set_mask;
        pending    = (event_q | level) & enable_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            event_q <= event_nx;
            if (en_we) begin
                enable_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/intc_decode.sv
// Address decode for the banked window and the read-data multiplexer.
module intc_decode
    import intc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 32,
    parameter int unsigned ADDR_W    = 6,
    localparam int unsigned NSRC     = NUM_BANKS * BANK_W,
    localparam int unsigned PAGE_W   = ADDR_W - PAGE_LSB
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [NSRC-1:0]      ev_all,
    input  logic [NSRC-1:0]      en_all,
    input  logic [NSRC-1:0]      lvl_all,
    output logic [NUM_BANKS-1:0] en_we,
    output logic [NUM_BANKS-1:0] ack_we,
    output logic [BANK_W-1:0]    rd_mux
);

    logic [PAGE_W-1:0]    page;
    logic                 aligned;
    reg_sel_e             sel;
    logic [NUM_BANKS-1:0] hit;

    always_comb begin
        page    = addr[ADDR_W-1:PAGE_LSB];
        aligned = (addr[1:0] == 2'b00);
        sel     = reg_sel_e'(addr[3:2]);
    end

    // Banks sit in reversed order: bank b lives at page NUM_BANKS-b.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        localparam int unsigned PAGE_OF_BANK = NUM_BANKS - b;
        always_comb begin
            hit[b]    = aligned && (page == PAGE_W'(PAGE_OF_BANK));
            en_we[b]  = wr && hit[b] && (sel == SEL_ENABLE);
            ack_we[b] = wr && hit[b] && (sel == SEL_ACK);
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b]) begin
                unique case (sel)
                    SEL_EVENT:  rd_mux = ev_all[b*BANK_W +: BANK_W];
                    SEL_ENABLE: rd_mux = en_all[b*BANK_W +: BANK_W];
                    SEL_ACK:    rd_mux = ev_all[b*BANK_W +: BANK_W];
                    SEL_LEVEL:  rd_mux = lvl_all[b*BANK_W +: BANK_W];
                    default:    rd_mux = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import intc_pkg::*;
#(
    parameter int unsigned NSRC   = 64,
    parameter int unsigned BANK_W = 32,
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned NUM_BANKS = NSRC / BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [NSRC-1:0]      lvl_all;
    logic [NSRC-1:0]      rise_all;
    logic [NSRC-1:0]      ev_all;
    logic [NSRC-1:0]      en_all;
    logic [NSRC-1:0]      pend_all;
    logic [NUM_BANKS-1:0] en_we;
    logic [NUM_BANKS-1:0] ack_we;
    logic [BANK_W-1:0]    rd_mux;
    logic [BANK_W-1:0]    rdata_q;

    irq_state_e state_q;
    irq_state_e state_nx;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_sync #(.WIDTH(BANK_W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (src_in[b*BANK_W +: BANK_W]),
            .level (lvl_all[b*BANK_W +: BANK_W]),
            .rise  (rise_all[b*BANK_W +: BANK_W])
        );

        intc_bank #(.WIDTH(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (lvl_all[b*BANK_W +: BANK_W]),
            .rise     (rise_all[b*BANK_W +: BANK_W]),
            .en_we    (en_we[b]),
            .ack_we   (ack_we[b]),
            .wdata    (bus_wdata),
            .event_q  (ev_all[b*BANK_W +: BANK_W]),
            .enable_q (en_all[b*BANK_W +: BANK_W]),
            .pending  (pend_all[b*BANK_W +: BANK_W])
        );
    end

    intc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .ev_all  (ev_all),
        .en_all  (en_all),
        .lvl_all (lvl_all),
        .en_we   (en_we),
        .ack_we  (ack_we),
        .rd_mux  (rd_mux)
    );

    // Read data register: one-cycle read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    // Request state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic: QUIET_TO_RAISED and RAISED_TO_QUIET.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (|pend_all)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!(|pend_all)) state_nx = IRQ_QUIET;
            default:    state_nx = IRQ_QUIET;
        endcase
    end

    // Outputs.
    always_comb begin
        irq_out   = (state_q == IRQ_RAISED);
        bus_rdata = rdata_q;
    end

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int unsigned NSRC   = 64,
    parameter int unsigned BANK_W = 32,
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned NUM_BANKS = NSRC / BANK_W,
    localparam int unsigned PAGE_W    = ADDR_W - 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BANK_W-1:0] bus_wdata,
    input logic [BANK_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic [NSRC-1:0]   ev_all,
    input logic [NSRC-1:0]   en_all,
    input logic [NSRC-1:0]   lvl_all
);

    logic [NSRC-1:0]   lvl_d;
    logic [NSRC-1:0]   rise_c;
    logic [NSRC-1:0]   clr_c;
    logic [PAGE_W-1:0] page;
    logic              undecoded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl_all;
    end

    always_comb begin
        rise_c    = lvl_all & ~lvl_d;
        page      = bus_addr[ADDR_W-1:4];
        undecoded = (bus_addr[1:0] != 2'b00) || (page == '0) ||
                    (32'(page) > NUM_BANKS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
        localparam int unsigned PG = NUM_BANKS - b;
        always_comb begin
            clr_c[b*BANK_W +: BANK_W] =
                (bus_wr && page == PAGE_W'(PG) && bus_addr[3:0] == 4'h8) ?
                bus_wdata : '0;
        end
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_c) |=> ((ev_all & $past(clr_c & ~(rise_c & en_all))) == '0)); // R7

    AST_EVENT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_all & ~$past(ev_all) & ~$past(rise_c & en_all)) == '0)); // R4

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(en_all)); // R3

    AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && undecoded) |=> (bus_rdata == '0)); // R10

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|((ev_all | lvl_all) & en_all))); // R11

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12

endmodule

bind banked_intc intc_chk #(
    .NSRC   (NSRC),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .ev_all    (ev_all),
    .en_all    (en_all),
    .lvl_all   (lvl_all)
);

// File: tb/sim_banked_intc.sv
`timescale 1ns/1ps
module sim_banked_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Register offsets (R2)
    localparam logic [5:0] B0_EV  = 6'h20, B0_EN = 6'h24, B0_ACK = 6'h28, B0_LV = 6'h2C;
    localparam logic [5:0] B1_EV  = 6'h10, B1_EN = 6'h14, B1_ACK = 6'h18, B1_LV = 6'h1C;

    always #2 clk = ~clk;   // 250 MHz

    banked_intc u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk); src_in[n] = 1'b1;
        @(negedge clk); src_in[n] = 1'b0;
        cycles(4);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        check("R1 rdata after reset", bus_rdata, 32'd0);
        bus_read(B0_EN, d); check("R1 bank0 enable", d, 32'd0);
        bus_read(B1_EV, d); check("R1 bank1 event", d, 32'd0);
    endtask

    task automatic t_enable_rw;
        logic [31:0] d;
        bus_write(B0_EN, 32'hA5A5_0001);
        bus_write(B1_EN, 32'h1234_5678);
        bus_read(B0_EN, d); check("R3 bank0 enable readback", d, 32'hA5A5_0001);
        bus_read(B1_EN, d); check("R3 bank1 enable readback", d, 32'h1234_5678);
        cycles(3);
        bus_read(B0_EN, d); check("R12 rdata holds between reads", bus_rdata, d);
        bus_write(B0_EN, 32'd0);
        bus_write(B1_EN, 32'd0);
        bus_read(B1_EN, d); check("R3 bank1 enable cleared", d, 32'd0);
    endtask

    task automatic t_edge_latch;
        logic [31:0] d;
        bus_write(B0_EN, 32'h0000_0008);
        bus_write(B1_EN, 32'h0000_0100);
        pulse(3);
        bus_read(B0_EV, d); check("R4 source 3 latched", d, 32'h0000_0008);
        check("R11 irq raised bank0", {31'd0, irq_out}, 32'd1);
        pulse(40);
        bus_read(B1_EV, d); check("R2 source 40 in bank1 bit 8", d, 32'h0000_0100);
        bus_read(B0_EV, d); check("R2 bank0 unaffected by source 40", d, 32'h0000_0008);
        bus_write(B0_ACK, 32'h0000_0000);
        bus_read(B0_EV, d); check("R7 zero ack keeps event", d, 32'h0000_0008);
        bus_read(B0_ACK, d); check("R7 ack readback", d, 32'h0000_0008);
        bus_write(B0_ACK, 32'h0000_0008);
        bus_read(B0_EV, d); check("R7 ack clears source 3", d, 32'd0);
        check("R11 irq held by bank1", {31'd0, irq_out}, 32'd1);
        bus_write(B1_ACK, 32'h0000_0100);
        cycles(2);
        check("R11 irq drops when nothing pending", {31'd0, irq_out}, 32'd0);
        bus_write(B0_EN, 32'd0);
        bus_write(B1_EN, 32'd0);
    endtask

    task automatic t_disabled_edge;
        logic [31:0] d;
        pulse(5);
        bus_read(B0_EV, d); check("R5 disabled edge not latched", d, 32'd0);
        check("R5 no irq from disabled edge", {31'd0, irq_out}, 32'd0);
        bus_write(B0_EN, 32'h0000_0020);
        cycles(2);
        bus_read(B0_EV, d); check("R5 late enable finds no event", d, 32'd0);
        bus_write(B0_EN, 32'd0);
    endtask

    task automatic t_enable_while_high;
        logic [31:0] d;
        @(negedge clk); src_in[10] = 1'b1;
        cycles(4);
        bus_write(B0_EN, 32'h0000_0400);
        cycles(3);
        bus_read(B0_EV, d); check("R6 enable on high line sets no event", d, 32'd0);
        bus_read(B0_LV, d); check("R9 level shows line 10", d, 32'h0000_0400);
        check("R6 irq follows level", {31'd0, irq_out}, 32'd1);
        @(negedge clk); src_in[10] = 1'b0;
        cycles(5);
        check("R6 irq falls with line", {31'd0, irq_out}, 32'd0);
        pulse(10);
        bus_read(B0_EV, d); check("R4 later edge latches", d, 32'h0000_0400);
        bus_write(B0_ACK, 32'h0000_0400);
        bus_write(B0_EN, 32'd0);
    endtask

    task automatic t_level_ro;
        logic [31:0] d;
        @(negedge clk); src_in[63] = 1'b1;
        cycles(4);
        bus_read(B1_LV, d); check("R9 level bank1 bit 31", d, 32'h8000_0000);
        bus_write(B1_LV, 32'h0000_0000);
        bus_write(B1_EV, 32'hFFFF_FFFF);
        bus_read(B1_LV, d); check("R9 level write ignored", d, 32'h8000_0000);
        bus_read(B1_EV, d); check("R9 event write ignored", d, 32'd0);
        @(negedge clk); src_in[63] = 1'b0;
        cycles(4);
        // Synchroniser latency on source 0.
        @(negedge clk);
        src_in[0] = 1'b1; bus_rd = 1'b1; bus_addr = B0_LV;
        @(negedge clk);
        @(negedge clk); check("R9 level not yet visible after 2 edges", bus_rdata, 32'd0);
        @(negedge clk); check("R9 level visible after sync", bus_rdata, 32'h0000_0001);
        bus_rd = 1'b0; src_in[0] = 1'b0;
        cycles(4);
    endtask

    task automatic t_undecoded;
        logic [31:0] d;
        bus_write(B0_EN, 32'h0000_00F0);
        bus_write(6'h00, 32'hFFFF_FFFF);
        bus_write(6'h34, 32'hFFFF_FFFF);
        bus_write(6'h25, 32'hFFFF_FFFF);
        bus_read(B0_EN, d); check("R10 undecoded writes ignored", d, 32'h0000_00F0);
        bus_read(6'h04, d); check("R10 offset 0x04 reads zero", d, 32'd0);
        bus_read(6'h34, d); check("R10 offset 0x34 reads zero", d, 32'd0);
        bus_read(6'h25, d); check("R10 unaligned reads zero", d, 32'd0);
        bus_write(B0_EN, 32'd0);
    endtask

    task automatic t_ack_race;
        logic [31:0] d;
        bus_write(B0_EN, 32'h0000_0080);
        pulse(7);
        bus_read(B0_EV, d); check("R8 precondition event set", d, 32'h0000_0080);
        @(negedge clk); src_in[7] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = B0_ACK; bus_wdata = 32'h0000_0080;
        @(negedge clk); bus_wr = 1'b0;
        bus_read(B0_EV, d); check("R8 edge wins over ack", d, 32'h0000_0080);
        @(negedge clk); src_in[7] = 1'b0;
        cycles(4);
        bus_write(B0_ACK, 32'h0000_0080);
        bus_read(B0_EV, d); check("R7 plain ack clears", d, 32'd0);
        bus_write(B0_EN, 32'd0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_enable_rw();
        t_edge_latch();
        t_disabled_edge();
        t_enable_while_high();
        t_level_ro();
        t_undecoded();
        t_ack_race();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule